// File: doc/BRIEF.md
# RAID Parity Stripe Engine

This block works out and verifies the XOR parity of one disk-array stripe, one data word at a time. A stripe holds `N_DATA` data strips and one parity strip, so `N_DATA + 1` physical disks are involved. Four jobs share a single XOR accumulator:

- A partial write updates one strip. It folds the strip's old word and the old parity into the new word, so the other strips are never read.
- A full-stripe write forms parity from the new words alone.
- A plain read checks that the whole stripe XORs to zero.
- A degraded read rebuilds the word of a failed disk from the disks that survive.

A controller issues a command carrying an operation code, a strip index, a stripe number and one failed-disk flag per physical disk. Parity is even, meaning the XOR of every data word and the parity word is zero. Parity alone cannot tell which disk holds a bad word, so the identity of a failed disk always comes from outside.

Words arrive on a valid/ready input stream. The order of the words is fixed by the operation, so no disk tag travels with them. Words leave on a valid/ready output stream, each tagged with the physical disk it belongs to. Every command ends with a one-cycle done pulse. Two status flags are meaningful only during that pulse.

Top module: `stripe_parity_engine`

## Requirements
- R1: `cmd_ready` is high only while the engine is idle. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` then stays low until the command's one-cycle `done` pulse has passed. Out of reset, `cmd_ready` is 1 and `in_ready`, `out_valid` and `done` are 0.
- R2: The parity disk of stripe s is selected by `ROTATE`:
  - With `ROTATE` = 1 it is N_DATA − (s mod (N_DATA+1)).
  - With `ROTATE` = 0 it is always disk N_DATA.
  - Data strip k sits on disk k when k is below the parity disk, and on disk k+1 otherwise.
- R3: Partial write uses op code 1.
  - It takes exactly three input words, in this order: the strip's old word, the old parity word, the new word.
  - It then emits the new word tagged with the strip's disk.
  - Last it emits old parity ^ old word ^ new word, tagged with the parity disk.
- R4: Full write uses op code 2.
  - It takes N_DATA words in strip order 0 upward.
  - Each word is emitted in the same order, tagged with its strip's disk.
  - It then emits the XOR of all of them, tagged with the parity disk.
- R5: Read uses op code 0. With all failed-disk flags clear, it takes N_DATA+1 words in ascending disk order and emits nothing. `err_parity` is high during `done` exactly when the XOR of those words is nonzero.
- R6: Read with exactly one failed-disk flag set on a data disk takes the N_DATA surviving words in ascending disk order. It then emits their XOR, tagged with the failed disk's index.
- R7: The command is rejected in any of these cases:
  - more than one failed-disk flag is set;
  - the single flag set during a read is on the parity disk;
  - the op code is 3;
  - a partial write names a strip index of N_DATA or more.

  A rejected command takes and emits no words, and `done` comes with `err_cmd` high. A single flag has no effect on writes.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_disk` hold their values. `in_ready` is low while an output word is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_op | input | 2 | 0 read, 1 partial write, 2 full write, 3 reserved |
| cmd_strip | input | IDX_W | Data strip index for a partial write |
| cmd_stripe | input | STRIPE_W | Stripe number, used to place parity |
| cmd_fail | input | N_DATA+1 | Failed-disk flags, bit i for physical disk i |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Engine takes the input word |
| in_data | input | DATA_W | Input word |
| out_valid | output | 1 | Output word pending |
| out_ready | input | 1 | Receiver takes the output word |
| out_data | output | DATA_W | Output word |
| out_disk | output | IDX_W | Physical disk the output word belongs to |
| done | output | 1 | One-cycle command completion pulse |
| err_parity | output | 1 | During done: plain read found a nonzero stripe XOR |
| err_cmd | output | 1 | During done: command was rejected |

## Verification
The hardest state to reach is an input arriving while an output word is still pending. This happens in a full write when the receiver stalls, and the stall must block the next input without losing word order or letting the pending word change. The bench drives `out_ready` from a random coin in a dedicated phase, so partial writes, full writes and degraded reads all meet stalls at different points in their sequences. A parity error cannot occur through writes, so the bench builds a consistent stripe itself and then flips one bit in one word before the check read. Stripe numbers run past the disk count, so the modulo in the parity placement wraps.

// File: rtl/stripe_pkg.sv
`timescale 1ns/1ps
package stripe_pkg;
   typedef enum logic [1:0] {
      OP_READ   = 2'd0,
      OP_PWRITE = 2'd1,
      OP_FWRITE = 2'd2,
      OP_RSVD   = 2'd3
   } stripe_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TAKE,
      ST_PUT_A,
      ST_PUT_B,
      ST_DRAIN,
      ST_DONE
   } eng_state_e;
endpackage

// File: rtl/stripe_layout.sv
`timescale 1ns/1ps
module stripe_layout #(
   parameter int N_DISK   = 5,
   parameter int IDX_W    = 3,
   parameter int STRIPE_W = 8,
   parameter bit ROTATE   = 1'b1
) (
   input  logic [STRIPE_W-1:0] stripe,
   output logic [IDX_W-1:0]    par_disk
);
   generate
      if (ROTATE) begin : g_rotate
         logic [STRIPE_W-1:0] slot;
         assign slot     = stripe % STRIPE_W'(N_DISK);
         assign par_disk = IDX_W'(N_DISK - 1) - IDX_W'(slot);
      end else begin : g_fixed
         logic unused_stripe;
         assign unused_stripe = ^stripe;
         assign par_disk      = IDX_W'(N_DISK - 1);
      end
   endgenerate
endmodule

// File: rtl/strip_place.sv
`timescale 1ns/1ps
module strip_place #(
   parameter int IDX_W = 3
) (
   input  logic [IDX_W-1:0] par_disk,
   input  logic [IDX_W-1:0] strip,
   output logic [IDX_W-1:0] disk
);
   // data strips skip over the parity slot
   assign disk = (strip < par_disk) ? strip : strip + IDX_W'(1);
endmodule

// File: rtl/cmd_screen.sv
`timescale 1ns/1ps
module cmd_screen
   import stripe_pkg::*;
#(
   parameter int N_DATA = 4,
   parameter int IDX_W  = 3,
   parameter int CNT_W  = 3
) (
   input  stripe_op_e         op,
   input  logic [IDX_W-1:0]   strip,
   input  logic [N_DATA:0]    fail,
   input  logic [IDX_W-1:0]   par_disk,
   output logic               bad,
   output logic               rebuild,
   output logic [IDX_W-1:0]   fail_disk,
   output logic [CNT_W-1:0]   need
);
   localparam int N_DISK = N_DATA + 1;

   int nfail;

   always_comb begin
      nfail     = 0;
      fail_disk = '0;
      for (int i = 0; i < N_DISK; i++) begin
         if (fail[i]) begin
            nfail     = nfail + 1;
            fail_disk = IDX_W'(i);
         end
      end
      bad = 1'b0;
      if (nfail > 1) bad = 1'b1;
      if (op == OP_RSVD) bad = 1'b1;
      if (op == OP_PWRITE && int'(strip) >= N_DATA) bad = 1'b1;
      if (op == OP_READ && nfail == 1 && fail_disk == par_disk) bad = 1'b1;
      rebuild = (op == OP_READ) && (nfail == 1) && !bad;
      case (op)
         OP_READ:   need = rebuild ? CNT_W'(N_DISK - 1) : CNT_W'(N_DISK);
         OP_PWRITE: need = CNT_W'(3);
         default:   need = CNT_W'(N_DATA);
      endcase
   end
endmodule

// File: rtl/xor_accum.sv
`timescale 1ns/1ps
module xor_accum #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else if (en)  q <= q ^ d;
   end
endmodule

// File: rtl/stripe_parity_engine.sv
`timescale 1ns/1ps
module stripe_parity_engine
   import stripe_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int N_DATA   = 4,
   parameter int IDX_W    = 3,
   parameter int STRIPE_W = 8,
   parameter bit ROTATE   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   output logic                cmd_ready,
   input  logic [1:0]          cmd_op,
   input  logic [IDX_W-1:0]    cmd_strip,
   input  logic [STRIPE_W-1:0] cmd_stripe,
   input  logic [N_DATA:0]     cmd_fail,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [DATA_W-1:0]   in_data,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [DATA_W-1:0]   out_data,
   output logic [IDX_W-1:0]    out_disk,
   output logic                done,
   output logic                err_parity,
   output logic                err_cmd
);
   localparam int N_DISK = N_DATA + 1;
   localparam int CNT_W  = $clog2(N_DISK + 1);

   generate
      if (N_DATA < 2) begin : g_chk_ndata
         $error("stripe_parity_engine: N_DATA must be at least 2");
      end
      if ((1 << IDX_W) < N_DISK) begin : g_chk_idx
         $error("stripe_parity_engine: IDX_W too narrow for the disk count");
      end
      if ((1 << STRIPE_W) <= N_DISK) begin : g_chk_stripe
         $error("stripe_parity_engine: STRIPE_W too narrow for the disk count");
      end
   endgenerate

   eng_state_e state_q, state_d;
   stripe_op_e op_q, cmd_op_e;

   logic [IDX_W-1:0]  par_now, tgt_now, fail_now, run_disk;
   logic              bad_now, rebuild_now;
   logic [CNT_W-1:0]  need_now;

   logic [IDX_W-1:0]  par_q, tgt_q, fail_q;
   logic              rebuild_q, cmd_bad_q, par_bad_q;
   logic [CNT_W-1:0]  need_q, cnt_q;
   logic [DATA_W-1:0] hold_q, acc_q;

   logic              out_valid_q;
   logic [DATA_W-1:0] out_data_q;
   logic [IDX_W-1:0]  out_disk_q;

   logic              cmd_fire, in_fire, last_in, out_pop;
   logic              load_en;
   logic [DATA_W-1:0] load_data;
   logic [IDX_W-1:0]  load_disk;

   assign cmd_op_e = stripe_op_e'(cmd_op);

   stripe_layout #(
      .N_DISK(N_DISK), .IDX_W(IDX_W), .STRIPE_W(STRIPE_W), .ROTATE(ROTATE)
   ) u_layout (
      .stripe(cmd_stripe), .par_disk(par_now)
   );

   strip_place #(.IDX_W(IDX_W)) u_tgt_place (
      .par_disk(par_now), .strip(cmd_strip), .disk(tgt_now)
   );

   strip_place #(.IDX_W(IDX_W)) u_run_place (
      .par_disk(par_q), .strip(IDX_W'(cnt_q)), .disk(run_disk)
   );

   cmd_screen #(.N_DATA(N_DATA), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_screen (
      .op(cmd_op_e), .strip(cmd_strip), .fail(cmd_fail), .par_disk(par_now),
      .bad(bad_now), .rebuild(rebuild_now), .fail_disk(fail_now), .need(need_now)
   );

   xor_accum #(.DATA_W(DATA_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(cmd_fire), .en(in_fire), .d(in_data), .q(acc_q)
   );

   assign cmd_ready = (state_q == ST_IDLE);
   assign cmd_fire  = cmd_valid && cmd_ready;
   assign in_ready  = (state_q == ST_TAKE) && !out_valid_q;
   assign in_fire   = in_valid && in_ready;
   assign last_in   = in_fire && (cnt_q == need_q - CNT_W'(1));
   assign out_pop   = out_valid_q && out_ready;

   always_comb begin
      state_d   = state_q;
      load_en   = 1'b0;
      load_data = acc_q;
      load_disk = par_q;
      case (state_q)
         ST_IDLE: begin
            if (cmd_valid) state_d = bad_now ? ST_DONE : ST_TAKE;
         end
         ST_TAKE: begin
            if (in_fire && op_q == OP_FWRITE) begin
               load_en   = 1'b1;
               load_data = in_data;
               load_disk = run_disk;
            end
            if (last_in) begin
               case (op_q)
                  OP_PWRITE: state_d = ST_PUT_A;
                  OP_FWRITE: state_d = ST_PUT_B;
                  default:   state_d = rebuild_q ? ST_PUT_B : ST_DONE;
               endcase
            end
         end
         ST_PUT_A: begin
            if (!out_valid_q) begin
               load_en   = 1'b1;
               load_data = hold_q;
               load_disk = tgt_q;
               state_d   = ST_PUT_B;
            end
         end
         ST_PUT_B: begin
            if (!out_valid_q) begin
               load_en   = 1'b1;
               load_data = acc_q;
               load_disk = rebuild_q ? fail_q : par_q;
               state_d   = ST_DRAIN;
            end
         end
         ST_DRAIN: begin
            if (!out_valid_q) state_d = ST_DONE;
         end
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         op_q        <= OP_READ;
         par_q       <= '0;
         tgt_q       <= '0;
         fail_q      <= '0;
         rebuild_q   <= 1'b0;
         need_q      <= '0;
         cnt_q       <= '0;
         hold_q      <= '0;
         cmd_bad_q   <= 1'b0;
         par_bad_q   <= 1'b0;
         out_valid_q <= 1'b0;
         out_data_q  <= '0;
         out_disk_q  <= '0;
      end else begin
         state_q <= state_d;
         if (cmd_fire) begin
            op_q      <= cmd_op_e;
            par_q     <= par_now;
            tgt_q     <= tgt_now;
            fail_q    <= fail_now;
            rebuild_q <= rebuild_now;
            need_q    <= need_now;
            cnt_q     <= '0;
            cmd_bad_q <= bad_now;
            par_bad_q <= 1'b0;
         end
         if (in_fire) begin
            cnt_q <= cnt_q + CNT_W'(1);
            // the last word of a partial write is the new strip word
            if (op_q == OP_PWRITE) hold_q <= in_data;
            if (last_in && op_q == OP_READ && !rebuild_q)
               par_bad_q <= |(acc_q ^ in_data);
         end
         if (load_en) begin
            out_valid_q <= 1'b1;
            out_data_q  <= load_data;
            out_disk_q  <= load_disk;
         end else if (out_pop) begin
            out_valid_q <= 1'b0;
         end
      end
   end

   assign out_valid  = out_valid_q;
   assign out_data   = out_data_q;
   assign out_disk   = out_disk_q;
   assign done       = (state_q == ST_DONE);
   assign err_cmd    = done && cmd_bad_q;
   assign err_parity = done && par_bad_q;
endmodule

// File: rtl/stripe_parity_engine_chk.sv
`timescale 1ns/1ps
module stripe_parity_engine_chk #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 3,
   parameter int N_DATA = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic [IDX_W-1:0]  out_disk,
   input logic              done,
   input logic              err_parity,
   input logic              err_cmd
);
   localparam int N_DISK = N_DATA + 1;

   assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cmd_ready);

   assert_idle_after_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> cmd_ready);

   assert_disk_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_disk) < N_DISK));

   assert_flag_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(err_cmd && err_parity));

   assert_flags_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cmd || err_parity) |-> done);

   assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!out_valid && !in_ready));

   assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_disk)));

   assert_in_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !out_valid);
endmodule

bind stripe_parity_engine stripe_parity_engine_chk #(
   .DATA_W(DATA_W), .IDX_W(IDX_W), .N_DATA(N_DATA)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
   .out_data(out_data), .out_disk(out_disk), .done(done),
   .err_parity(err_parity), .err_cmd(err_cmd)
);

// File: tb/stripe_parity_engine_bench.sv
`timescale 1ns/1ps
module stripe_parity_engine_bench;
   localparam int DW = 32, NDATA = 4, ND = 5, IW = 3, SW = 8;
   localparam bit ROT = 1'b1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_ready;
   logic [1:0] cmd_op = '0;
   logic [IW-1:0] cmd_strip = '0;
   logic [SW-1:0] cmd_stripe = '0;
   logic [ND-1:0] cmd_fail = '0;
   logic in_valid = 1'b0, in_ready;
   logic [DW-1:0] in_data = '0;
   logic out_valid, out_ready = 1'b0;
   logic [DW-1:0] out_data;
   logic [IW-1:0] out_disk;
   logic done, err_parity, err_cmd;

   always #2.5 clk = ~clk;

   stripe_parity_engine #(
      .DATA_W(DW), .N_DATA(NDATA), .IDX_W(IW), .STRIPE_W(SW), .ROTATE(ROT)
   ) u_stripe_parity_engine (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_strip(cmd_strip), .cmd_stripe(cmd_stripe), .cmd_fail(cmd_fail),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_disk(out_disk),
      .done(done), .err_parity(err_parity), .err_cmd(err_cmd)
   );

   int checks = 0, fails = 0, dones = 0, cycles = 0;
   bit bp = 1'b0;
   logic [DW-1:0] exp_data_q[$];
   int            exp_disk_q[$];
   string         exp_tag_q[$];
   logic [1:0]    exp_flag_q[$];
   string         exp_ftag_q[$];
   bit            prev_stall = 1'b0;
   logic [DW-1:0] prev_data = '0;
   logic [IW-1:0] prev_disk = '0;
   logic [DW-1:0] m_d;
   int            m_k;
   string         m_t;
   logic [1:0]    m_f;

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int par_of(int s);
      return ROT ? (ND - 1 - (s % ND)) : ND - 1;
   endfunction

   function automatic int disk_of(int k, int s);
      return (k < par_of(s)) ? k : k + 1;
   endfunction

   task automatic push_word(logic [DW-1:0] d, int k, string t);
      exp_data_q.push_back(d); exp_disk_q.push_back(k); exp_tag_q.push_back(t);
   endtask

   task automatic push_flags(logic [1:0] f, string t);
      exp_flag_q.push_back(f); exp_ftag_q.push_back(t);
   endtask

   // per-cycle comparison against the expected streams
   always @(negedge clk) begin
      if (rst_n) begin
         out_ready = bp ? ($urandom_range(0, 1) == 1) : 1'b1;
         if (prev_stall)
            check(out_valid && out_data == prev_data && out_disk == prev_disk,
                  "R8", "stalled word held", {out_disk, out_data}, {prev_disk, prev_data});
         if (out_valid && out_ready) begin
            if (exp_data_q.size() == 0) begin
               check(1'b0, "R7", "unexpected output word", out_data, 0);
            end else begin
               m_d = exp_data_q.pop_front(); m_k = exp_disk_q.pop_front(); m_t = exp_tag_q.pop_front();
               check(out_data == m_d && int'(out_disk) == m_k, m_t, "output word/disk",
                     {out_disk, out_data}, {m_k[IW-1:0], m_d});
            end
         end
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
         prev_disk  = out_disk;
         if (done) begin
            if (exp_flag_q.size() == 0) begin
               check(1'b0, "R1", "unexpected done", 1, 0);
            end else begin
               m_f = exp_flag_q.pop_front(); m_t = exp_ftag_q.pop_front();
               check({err_cmd, err_parity} == m_f, m_t, "done flags {err_cmd,err_parity}",
                     {err_cmd, err_parity}, m_f);
            end
            dones++;
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles == 100000) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic send_cmd(int op, int strip, int stripe, logic [ND-1:0] fail);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'(op); cmd_strip = IW'(strip);
      cmd_stripe = SW'(stripe); cmd_fail = fail;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(!cmd_ready, "R1", "cmd_ready low after accept", cmd_ready, 0);
   endtask

   task automatic send_word(logic [DW-1:0] w);
      in_valid = 1'b1; in_data = w;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic wait_done(int base);
      while (dones <= base) @(negedge clk);
   endtask

   task automatic do_fwrite(int s, logic [DW-1:0] w [NDATA], logic [ND-1:0] fail, string t);
      int base;
      logic [DW-1:0] p;
      base = dones; p = '0;
      for (int k = 0; k < NDATA; k++) begin
         push_word(w[k], disk_of(k, s), t);
         p ^= w[k];
      end
      push_word(p, par_of(s), t);
      push_flags(2'b00, t);
      send_cmd(2, 0, s, fail);
      for (int k = 0; k < NDATA; k++) send_word(w[k]);
      wait_done(base);
   endtask

   task automatic do_pwrite(int s, int strip, logic [DW-1:0] od, logic [DW-1:0] opar, logic [DW-1:0] nd);
      int base;
      base = dones;
      push_word(nd, disk_of(strip, s), "R3");
      push_word(opar ^ od ^ nd, par_of(s), "R3");
      push_flags(2'b00, "R3");
      send_cmd(1, strip, s, '0);
      send_word(od); send_word(opar); send_word(nd);
      wait_done(base);
   endtask

   task automatic build_stripe(int s, output logic [DW-1:0] phys [ND]);
      logic [DW-1:0] p;
      logic [DW-1:0] w;
      p = '0;
      for (int k = 0; k < NDATA; k++) begin
         w = $urandom();
         phys[disk_of(k, s)] = w;
         p ^= w;
      end
      phys[par_of(s)] = p;
   endtask

   task automatic do_read(int s, logic [DW-1:0] phys [ND], int f, bit exp_err);
      int base;
      logic [DW-1:0] x;
      base = dones; x = '0;
      if (f < 0) begin
         push_flags({1'b0, exp_err}, "R5");
         send_cmd(0, 0, s, '0);
         for (int i = 0; i < ND; i++) send_word(phys[i]);
      end else begin
         for (int i = 0; i < ND; i++) if (i != f) x ^= phys[i];
         push_word(x, f, "R6");
         push_flags(2'b00, "R6");
         send_cmd(0, 0, s, ND'(1 << f));
         for (int i = 0; i < ND; i++) if (i != f) send_word(phys[i]);
      end
      wait_done(base);
   endtask

   task automatic do_bad(int op, int strip, int s, logic [ND-1:0] fail);
      int base;
      base = dones;
      push_flags(2'b10, "R7");
      send_cmd(op, strip, s, fail);
      wait_done(base);
   endtask

   initial begin
      logic [DW-1:0] w [NDATA];
      logic [DW-1:0] phys [ND];
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check(cmd_ready == 1'b1, "R1", "reset cmd_ready", cmd_ready, 1);
      check(in_ready == 1'b0, "R1", "reset in_ready", in_ready, 0);
      check(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
      check(done == 1'b0, "R1", "reset done", done, 0);

      // R2 and R4: full writes over stripes that wrap the rotation
      for (int s = 0; s < 8; s++) begin
         for (int k = 0; k < NDATA; k++) w[k] = $urandom();
         do_fwrite(s, w, '0, (s < 5) ? "R4" : "R2");
      end
      for (int k = 0; k < NDATA; k++) w[k] = 32'hFFFF_FFFF;
      do_fwrite(9, w, '0, "R4");

      // R3: partial write of every strip with parity in every slot
      for (int s = 0; s < 5; s++)
         for (int k = 0; k < NDATA; k++)
            do_pwrite(s, k, $urandom(), $urandom(), $urandom());

      // R5: consistent and corrupted check reads
      for (int s = 0; s < 5; s++) begin
         build_stripe(s, phys);
         do_read(s, phys, -1, 1'b0);
         phys[$urandom_range(0, ND - 1)] ^= DW'(1) << $urandom_range(0, DW - 1);
         do_read(s, phys, -1, 1'b1);
      end

      // R6: rebuild every data disk of several stripes
      for (int s = 0; s < 5; s++) begin
         build_stripe(s, phys);
         for (int f = 0; f < ND; f++)
            if (f != par_of(s)) do_read(s, phys, f, 1'b0);
      end

      // R7: rejected commands, then a write with a single flag set
      do_bad(0, 0, 3, 5'b00011);
      do_bad(2, 0, 1, 5'b10100);
      do_bad(1, 1, 0, 5'b11000);
      for (int s = 0; s < 5; s++) do_bad(0, 0, s, ND'(1 << par_of(s)));
      do_bad(3, 0, 0, '0);
      do_bad(1, 4, 0, '0);
      do_bad(1, 7, 2, '0);
      for (int k = 0; k < NDATA; k++) w[k] = $urandom();
      do_fwrite(2, w, 5'b00001, "R7");

      // R8: receiver stalls across all output-producing commands
      bp = 1'b1;
      for (int s = 0; s < 6; s++) begin
         for (int k = 0; k < NDATA; k++) w[k] = $urandom();
         do_fwrite(s, w, '0, "R8");
         do_pwrite(s, s % NDATA, $urandom(), $urandom(), $urandom());
         build_stripe(s, phys);
         do_read(s, phys, disk_of(s % NDATA, s), 1'b0);
      end
      bp = 1'b0;
      repeat (4) @(negedge clk);

      check(exp_data_q.size() == 0, "R1", "all expected words seen", exp_data_q.size(), 0);
      check(exp_flag_q.size() == 0, "R1", "all expected done pulses seen", exp_flag_q.size(), 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule